// File: doc/BRIEF.md
# Paged Extended RAM Window

The block gives a host an 8 KB byte store through a very small I/O footprint. The host sees two things. The first is a 32-byte data window. The second is an 8-bit page register that picks which of 256 pages the window currently shows. Address bit 5 chooses between them. With bit 5 low, bits 4..0 pick a byte inside the selected page. With bit 5 high, the page register answers at all 32 offsets. The storage byte index is the page value placed above the 5-bit offset.

A control state machine serves each bus access. The machine leaves `ST_IDLE` on the first clock edge where the chip select and exactly one strobe are low. A window read goes to `ST_RD_WIN`. A page-register read goes to `ST_RD_PAGE`. Any write goes to `ST_WR_HOLD`. The write is committed on the edge that leaves `ST_IDLE`. The machine stays in a read or hold state while the access continues. It goes back to `ST_IDLE` on the first edge where the chip select or the strobe has been released.

Read data appears on `rdata` only while `rdata_oe` is high. This bus-release model stands in for a tri-state driver.

Top module: `paged_xram_window`

## Requirements
- R1: After reset the page register holds 0, `rdata_oe` is low and `rdata` is 0.
- R2: A write with `addr[5]`=0 stores `wdata` at byte index {page, `addr[4:0]`}. A later read of the same page and offset returns that byte.
- R3: With `addr[5]`=1, reads and writes reach the page register whatever `addr[4:0]` holds. A read returns the value last written. The new page applies from the next window access onward.
- R4: The same offset in different pages holds independent bytes. A write in one page leaves the other pages unchanged.
- R5: While `cs_n` is high, the strobes are ignored. Nothing is written, and `rdata_oe` stays low.
- R6: `rdata_oe` is high only during a read with `cs_n` and `rd_n` both low, and `rdata` is 0 whenever `rdata_oe` is low. Releasing either signal drops `rdata_oe` in the same cycle.
- R7: If `rd_n` and `wr_n` are both low on the starting edge, the access is ignored. The machine stays in `ST_IDLE`, and neither the page nor the store changes.
- R8: Read data becomes valid on the first clock edge after the read is seen, not before. It stays stable for as long as the read is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| addr | input | 6 | Bit 5 selects the page register; bits 4..0 select the byte offset |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, 0 while not driven |
| rdata_oe | output | 1 | High while the block drives `rdata` |

## Verification
Four properties are checked on every cycle by in-line assertions:
- the output enable appears only after a read was active on the previous edge;
- the page register holds still unless a selected write occurred;
- the store's write port fires only for a selected, unambiguous write;
- a conflicting strobe pair leaves the machine in `ST_IDLE`.

Other behaviours need a sequence of accesses and an independent model of the store, so only the bench scenarios show them. These are page isolation at a shared offset, aliasing of the page register over all offsets, that a page change applies to the following access, and the one-cycle read latency.

// File: rtl/xram_pkg.sv
package xram_pkg;
    localparam int OFF_W  = 5;
    localparam int PAGE_W = 8;
    localparam int DATA_W = 8;
    localparam int ADDR_W = OFF_W + 1;
    localparam int IDX_W  = PAGE_W + OFF_W;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RD_WIN  = 2'd1,
        ST_RD_PAGE = 2'd2,
        ST_WR_HOLD = 2'd3
    } xram_state_t;
endpackage

// File: rtl/xram_page_reg.sv
module xram_page_reg #(
    parameter int PAGE_W = xram_pkg::PAGE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [PAGE_W-1:0] wdata,
    output logic [PAGE_W-1:0] page
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page <= '0;
        end else if (we) begin
            page <= wdata;
        end
    end
endmodule

// File: rtl/xram_store.sv
module xram_store #(
    parameter int DATA_W = xram_pkg::DATA_W,
    parameter int IDX_W  = xram_pkg::IDX_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic              re,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[idx] <= wdata;
        end
        if (re) begin
            rdata <= cells[idx];
        end
    end
endmodule

// File: rtl/xram_ctrl.sv
module xram_ctrl
    import xram_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cs_n,
    input  logic        rd_n,
    input  logic        wr_n,
    input  logic        sel_page,
    output xram_state_t state,
    output logic        mem_re,
    output logic        mem_we,
    output logic        page_we,
    output logic        rdata_oe
);
    xram_state_t state_nx;
    logic        start_rd;
    logic        start_wr;
    logic        rd_live;
    logic        wr_live;

    assign rd_live  = !cs_n && !rd_n;
    assign wr_live  = !cs_n && !wr_n;
    assign start_rd = rd_live && wr_n;
    assign start_wr = wr_live && rd_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (start_rd) begin
                    state_nx = sel_page ? ST_RD_PAGE : ST_RD_WIN;
                end else if (start_wr) begin
                    state_nx = ST_WR_HOLD;
                end
            end
            ST_RD_WIN, ST_RD_PAGE: begin
                if (!rd_live) begin
                    state_nx = ST_IDLE;
                end
            end
            ST_WR_HOLD: begin
                if (!wr_live) begin
                    state_nx = ST_IDLE;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        mem_re   = 1'b0;
        mem_we   = 1'b0;
        page_we  = 1'b0;
        rdata_oe = 1'b0;
        unique case (state)
            ST_IDLE: begin
                mem_re  = start_rd && !sel_page;
                mem_we  = start_wr && !sel_page;
                page_we = start_wr && sel_page;
            end
            ST_RD_WIN, ST_RD_PAGE: begin
                rdata_oe = rd_live;
            end
            ST_WR_HOLD: begin
                rdata_oe = 1'b0;
            end
            default: begin
                rdata_oe = 1'b0;
            end
        endcase
    end

    // R6
    oe_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_oe |-> $past(!cs_n && !rd_n));

    // R5
    store_we_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (!cs_n && !wr_n && rd_n));

    // R7
    both_strobes_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !cs_n && !rd_n && !wr_n) |=> (state == ST_IDLE));
endmodule

// File: rtl/paged_xram_window.sv
module paged_xram_window
    import xram_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_oe
);
    xram_state_t       state;
    logic              mem_re;
    logic              mem_we;
    logic              page_we;
    logic [PAGE_W-1:0] page;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] mem_rdata;

    assign idx = {page, addr[OFF_W-1:0]};

    xram_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .sel_page (addr[OFF_W]),
        .state    (state),
        .mem_re   (mem_re),
        .mem_we   (mem_we),
        .page_we  (page_we),
        .rdata_oe (rdata_oe)
    );

    xram_page_reg #(.PAGE_W(PAGE_W)) u_page (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (page_we),
        .wdata (wdata[PAGE_W-1:0]),
        .page  (page)
    );

    xram_store #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_store (
        .clk   (clk),
        .we    (mem_we),
        .re    (mem_re),
        .idx   (idx),
        .wdata (wdata),
        .rdata (mem_rdata)
    );

    always_comb begin
        rdata = '0;
        if (rdata_oe) begin
            rdata = (state == ST_RD_PAGE) ? DATA_W'(page) : mem_rdata;
        end
    end

    // R3
    page_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n || wr_n) |=> $stable(page));
endmodule

// File: tb/sim_paged_xram_window.sv
module sim_paged_xram_window;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic [5:0] addr = '0;
    logic       rd_n = 1'b1;
    logic       wr_n = 1'b1;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       rdata_oe;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];
    event       ev_sample;

    always #5 clk = ~clk;

    paged_xram_window u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .addr(addr), .rd_n(rd_n),
        .wr_n(wr_n), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    initial begin : monitor
        forever begin
            @(ev_sample);
            if (exp_q.size() > 0) begin
                logic [7:0] e;
                string      t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(rdata_oe === 1'b1, {t, " oe"}, int'(rdata_oe), 1);
                check(rdata === e, t, int'(rdata), int'(e));
            end
        end
    end

    task automatic bus_write(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; cs_n = 1'b0; wr_n = 1'b0;
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic bus_read(input logic [5:0] a, input logic [7:0] e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        addr = a; cs_n = 1'b0; rd_n = 1'b0;
        @(posedge clk);
        #2 -> ev_sample;
        #1;
        @(negedge clk);
        cs_n = 1'b1; rd_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin : watchdog
        #500000;
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_up();
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        #2;
        // R1 reset state
        check(rdata_oe === 1'b0, "R1 oe at reset", int'(rdata_oe), 0);
        check(rdata === 8'h00, "R1 rdata at reset", int'(rdata), 0);
        rst_n = 1'b1;
        bus_read(6'h20, 8'h00, "R1 page after reset");

        // R3 page register aliases
        bus_write(6'h20, 8'h05);
        bus_read(6'h3F, 8'h05, "R3 alias read 3F");
        bus_write(6'h2A, 8'h9C);
        bus_read(6'h31, 8'h9C, "R3 alias read 31");

        // R2 / R4 window data across pages
        bus_write(6'h20, 8'd3);
        bus_write(6'h00, 8'h11);
        bus_write(6'h1F, 8'h22);
        bus_write(6'h11, 8'h33);
        bus_write(6'h20, 8'd200);
        bus_write(6'h00, 8'hA1);
        bus_write(6'h1F, 8'hA2);
        bus_write(6'h20, 8'd255);
        bus_write(6'h1F, 8'hFE);
        bus_read(6'h1F, 8'hFE, "R2 page 255 top offset");
        bus_write(6'h20, 8'd3);
        bus_read(6'h00, 8'h11, "R4 page 3 offset 0");
        bus_read(6'h1F, 8'h22, "R4 page 3 offset 31");
        bus_read(6'h11, 8'h33, "R2 page 3 offset 17");
        bus_write(6'h20, 8'd200);
        bus_read(6'h00, 8'hA1, "R4 page 200 offset 0");
        bus_read(6'h1F, 8'hA2, "R3 new page used by next access");

        // R5 strobes ignored with cs_n high
        @(negedge clk);
        addr = 6'h00; wdata = 8'h77; cs_n = 1'b1; wr_n = 1'b0;
        @(negedge clk);
        wr_n = 1'b1; rd_n = 1'b0;
        @(posedge clk);
        #2;
        check(rdata_oe === 1'b0, "R5 oe with cs_n high", int'(rdata_oe), 0);
        check(rdata === 8'h00, "R5 rdata with cs_n high", int'(rdata), 0);
        @(negedge clk);
        rd_n = 1'b1;
        bus_read(6'h00, 8'hA1, "R5 byte unchanged");

        // R7 conflicting strobes ignored
        @(negedge clk);
        addr = 6'h20; wdata = 8'h44; cs_n = 1'b0; rd_n = 1'b0; wr_n = 1'b0;
        @(posedge clk);
        #2;
        check(rdata_oe === 1'b0, "R7 no output on conflict", int'(rdata_oe), 0);
        @(negedge clk);
        cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
        @(negedge clk);
        bus_read(6'h20, 8'd200, "R7 page unchanged");

        // R8 / R6 read latency, hold and release
        @(negedge clk);
        addr = 6'h1F; cs_n = 1'b0; rd_n = 1'b0;
        #2;
        check(rdata_oe === 1'b0, "R8 not valid before edge", int'(rdata_oe), 0);
        for (int k = 0; k < 3; k++) begin
            @(posedge clk);
            #2;
            check(rdata_oe === 1'b1 && rdata === 8'hA2, "R8 held read stable",
                  int'(rdata), 8'hA2);
        end
        @(negedge clk);
        rd_n = 1'b1;
        #1;
        check(rdata_oe === 1'b0, "R6 oe drops on release", int'(rdata_oe), 0);
        check(rdata === 8'h00, "R6 rdata zero when released", int'(rdata), 0);
        cs_n = 1'b1;
        @(negedge clk);

        repeat (3) @(negedge clk);
        finish_up();
    end
endmodule